// File: doc/BRIEF.md
# Indirect Configuration Space Access Port

This block sits inside a host-to-PCI style bridge and gives the host a narrow, register-mapped path to the configuration and I/O-port spaces of the devices downstream. The host first writes a 32-bit target word into a single address register. It then reads or writes one of two data windows. The window it touches selects the kind of downstream cycle, either configuration or I/O port, and that cycle is launched using the address that is currently latched.

The lanes for a byte or halfword access are taken from the low offset bits of the window access itself, not from the latched target word. A configuration cycle carries the bus, device/function and dword-aligned register fields of the target word. An I/O-port cycle carries the low 16 bits of the target word unchanged. Only one downstream cycle is in flight at a time. The host is held off with ready low until the response returns, and read data comes back in its lane positions with the other lanes forced to zero. Before a configuration write, software can issue a configuration read with register offset zero as a harmless priming access. That read is an ordinary cycle and needs no special handling.

Top module: `ind_cfg_port`

## Requirements
- R1: After reset the address register reads as zero, no downstream request is pending and host ready is low while no host request is presented.
- R2: A host write to offset 0x064 loads all 32 bits of the address register and completes with ready high in the same cycle, with no downstream cycle. A read at 0x064 returns the register the same way.
- R3: An access to offset 0x068 launches a configuration cycle (kind 0). Its address is bits 23:16 bus, 15:8 device/function and 7:2 register taken from the latched word, with bits 1:0 and 31:24 zero.
- R4: An access to offset 0x06C launches an I/O-port cycle (kind 1). Its address is bits 15:0 of the latched word, with bits 31:16 zero.
- R5: Access size encoding is 00 byte, 01 halfword, 10 or 11 word. Byte enables are computed from it and the window offset bits [1:0]: a byte access sets lane 1<<offset, a halfword sets lanes 3:2 when offset bit 1 is set and lanes 1:0 otherwise, and a word sets all four lanes.
- R6: The downstream write flag follows the host write flag. Downstream write data equals host write data with the disabled lanes zeroed.
- R7: Host ready stays low from launch until the downstream acknowledge. Ready rises for exactly one cycle in the cycle after the acknowledge. Read data then holds the response in the enabled lanes and zero elsewhere, and is zero for writes.
- R8: While a downstream cycle is outstanding, a host write to the address register is not accepted. Ready stays low, the downstream address stays stable and the register keeps its old value.
- R9: A configuration read whose register field is zero launches a normal configuration cycle with address bits 7:0 zero and leaves the address register unchanged. A following configuration write uses the same latched target.
- R10: An access to any other offset completes at once with ready high and read data zero. It launches no downstream cycle and leaves the address register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_req_i | input | 1 | Host access request, held until ready |
| host_we_i | input | 1 | Host write (1) or read (0) |
| host_addr_i | input | HOST_AW | Host byte offset |
| host_size_i | input | 2 | Access size: 00 byte, 01 half, 1x word |
| host_wdata_i | input | 32 | Host write data, lane aligned |
| host_rdata_o | output | 32 | Host read data, lane aligned |
| host_ready_o | output | 1 | Access complete |
| dn_req_o | output | 1 | Downstream cycle pending |
| dn_kind_o | output | 1 | Cycle kind: 0 configuration, 1 I/O port |
| dn_we_o | output | 1 | Downstream write |
| dn_addr_o | output | 32 | Downstream address |
| dn_be_o | output | 4 | Downstream byte enables |
| dn_wdata_o | output | 32 | Downstream write data |
| dn_ack_i | input | 1 | Downstream response strobe |
| dn_rdata_i | input | 32 | Downstream response data |

## Verification
The assertions watch, on every cycle, that a pending request holds its address, lanes and kind until it is acknowledged. They also check that ready stays low while a request is pending and rises right after the acknowledge, that configuration addresses keep bits 1:0 and 31:24 clear, that I/O addresses keep the upper half clear, that byte enables form a legal contiguous group, and that disabled lanes carry zero in both directions. Only the bench scenarios can show the mapping of the three offsets, the exact field placement of the target word, the lane chosen for every size and offset, the refused address write during a pending cycle, the priming read, and accesses to unmapped offsets.

// File: rtl/ind_cfg_port_pkg.sv
`timescale 1ns/1ps
package ind_cfg_port_pkg;
  parameter int unsigned DATA_W = 32;
  localparam int unsigned LANES = DATA_W / 8;

  typedef enum logic {CYC_CFG = 1'b0, CYC_IO = 1'b1} cyc_kind_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_BUSY = 2'd1, ST_DONE = 2'd2} seq_state_e;

  function automatic logic [DATA_W-1:0] lanes_to_mask(input logic [LANES-1:0] be);
    logic [DATA_W-1:0] m;
    for (int b = 0; b < LANES; b++) m[b*8 +: 8] = {8{be[b]}};
    return m;
  endfunction
endpackage

// File: rtl/ind_cfg_lane.sv
`timescale 1ns/1ps
module ind_cfg_lane
  import ind_cfg_port_pkg::*;
(
  input  logic [1:0]        ofs_i,
  input  logic [1:0]        size_i,
  output logic [LANES-1:0]  be_o,
  output logic [DATA_W-1:0] mask_o
);
  always_comb begin
    unique case (size_i)
      2'b00:   be_o = LANES'(1) << ofs_i;
      2'b01:   be_o = ofs_i[1] ? 4'b1100 : 4'b0011;
      default: be_o = '1;
    endcase
  end

  for (genvar b = 0; b < LANES; b++) begin : g_mask
    assign mask_o[b*8 +: 8] = {8{be_o[b]}};
  end
endmodule

// File: rtl/ind_cfg_addr_fmt.sv
`timescale 1ns/1ps
module ind_cfg_addr_fmt
  import ind_cfg_port_pkg::*;
#(
  parameter int unsigned TOK_W  = 24,
  parameter int unsigned PORT_W = 16
) (
  input  logic [TOK_W-1:0]  tgt_i,
  input  cyc_kind_e         kind_i,
  output logic [DATA_W-1:0] addr_o
);
  logic [DATA_W-1:0] cfg_addr, io_addr;

  // config token: dword aligned, upper byte clear
  assign cfg_addr = {{(DATA_W-TOK_W){1'b0}}, tgt_i[TOK_W-1:2], 2'b00};
  assign io_addr  = {{(DATA_W-PORT_W){1'b0}}, tgt_i[PORT_W-1:0]};
  assign addr_o   = (kind_i == CYC_IO) ? io_addr : cfg_addr;
endmodule

// File: rtl/ind_cfg_seq.sv
`timescale 1ns/1ps
module ind_cfg_seq
  import ind_cfg_port_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  input  logic ack_i,
  output logic idle_o,
  output logic busy_o,
  output logic done_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (launch_i) state_d = ST_BUSY;
      ST_BUSY: if (ack_i)    state_d = ST_DONE;
      default:               state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign idle_o = (state_q == ST_IDLE);
  assign busy_o = (state_q == ST_BUSY);
  assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/ind_cfg_port.sv
`timescale 1ns/1ps
module ind_cfg_port
  import ind_cfg_port_pkg::*;
#(
  parameter int unsigned         HOST_AW  = 12,
  parameter logic [HOST_AW-1:0]  OFS_ADDR = 'h064,
  parameter logic [HOST_AW-1:0]  OFS_CFG  = 'h068,
  parameter logic [HOST_AW-1:0]  OFS_IO   = 'h06C,
  parameter int unsigned         TOK_W    = 24,
  parameter int unsigned         PORT_W   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_req_i,
  input  logic               host_we_i,
  input  logic [HOST_AW-1:0] host_addr_i,
  input  logic [1:0]         host_size_i,
  input  logic [31:0]        host_wdata_i,
  output logic [31:0]        host_rdata_o,
  output logic               host_ready_o,
  output logic               dn_req_o,
  output logic               dn_kind_o,
  output logic               dn_we_o,
  output logic [31:0]        dn_addr_o,
  output logic [3:0]         dn_be_o,
  output logic [31:0]        dn_wdata_o,
  input  logic               dn_ack_i,
  input  logic [31:0]        dn_rdata_i
);
  localparam int unsigned WSEL_LO = 2;

  logic hit_addr, hit_cfg, hit_io, hit_win;
  logic idle, busy, done, launch;
  logic [LANES-1:0]  lane_be;
  logic [DATA_W-1:0] lane_mask;

  logic [DATA_W-1:0] addr_q, wdata_q, rdata_q;
  logic [LANES-1:0]  be_q;
  logic              we_q;
  cyc_kind_e         kind_q;

  assign hit_addr = host_addr_i[HOST_AW-1:WSEL_LO] == OFS_ADDR[HOST_AW-1:WSEL_LO];
  assign hit_cfg  = host_addr_i[HOST_AW-1:WSEL_LO] == OFS_CFG[HOST_AW-1:WSEL_LO];
  assign hit_io   = host_addr_i[HOST_AW-1:WSEL_LO] == OFS_IO[HOST_AW-1:WSEL_LO];
  assign hit_win  = hit_cfg | hit_io;
  assign launch   = host_req_i & idle & hit_win;

  ind_cfg_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch),
    .ack_i    (dn_ack_i),
    .idle_o   (idle),
    .busy_o   (busy),
    .done_o   (done)
  );

  ind_cfg_lane u_lane (
    .ofs_i  (host_addr_i[1:0]),
    .size_i (host_size_i),
    .be_o   (lane_be),
    .mask_o (lane_mask)
  );

  ind_cfg_addr_fmt #(.TOK_W(TOK_W), .PORT_W(PORT_W)) u_fmt (
    .tgt_i  (addr_q[TOK_W-1:0]),
    .kind_i (kind_q),
    .addr_o (dn_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      kind_q  <= CYC_CFG;
      we_q    <= 1'b0;
      be_q    <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      // address register only moves when nothing is in flight
      if (host_req_i && idle && hit_addr && host_we_i) addr_q <= host_wdata_i;
      if (launch) begin
        kind_q  <= hit_io ? CYC_IO : CYC_CFG;
        we_q    <= host_we_i;
        be_q    <= lane_be;
        wdata_q <= host_wdata_i & lane_mask;
      end
      if (busy && dn_ack_i) rdata_q <= we_q ? '0 : (dn_rdata_i & lanes_to_mask(be_q));
    end
  end

  assign host_ready_o = done | (host_req_i & idle & ~hit_win);
  assign host_rdata_o = done ? rdata_q
                      : (host_req_i && idle && hit_addr && !host_we_i) ? addr_q : '0;

  assign dn_req_o   = busy;
  assign dn_kind_o  = kind_q;
  assign dn_we_o    = we_q;
  assign dn_be_o    = be_q;
  assign dn_wdata_o = wdata_q;
endmodule

// File: rtl/ind_cfg_port_chk.sv
`timescale 1ns/1ps
module ind_cfg_port_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        host_ready_o,
  input logic [31:0] host_rdata_o,
  input logic        dn_req_o,
  input logic        dn_kind_o,
  input logic        dn_we_o,
  input logic [31:0] dn_addr_o,
  input logic [3:0]  dn_be_o,
  input logic [31:0] dn_wdata_o,
  input logic        dn_ack_i
);
  function automatic logic [31:0] m4(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_o && !dn_ack_i |=> dn_req_o && $stable(dn_addr_o) && $stable(dn_be_o) && $stable(dn_kind_o));

  assert_no_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_o |-> !host_ready_o);

  assert_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_o && dn_ack_i |=> host_ready_o && !dn_req_o);

  assert_cfg_fmt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_o && !dn_kind_o |-> dn_addr_o[1:0] == 2'b00 && dn_addr_o[31:24] == 8'h00);

  assert_io_fmt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_o && dn_kind_o |-> dn_addr_o[31:16] == 16'h0000);

  assert_lanes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_o |-> dn_be_o inside {4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011, 4'b1100, 4'b1111});

  assert_wdata_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_o && dn_we_o |-> (dn_wdata_o & ~m4(dn_be_o)) == 32'h0);

  assert_rmask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_o && dn_ack_i && !dn_we_o |=> (host_rdata_o & ~m4($past(dn_be_o))) == 32'h0);
endmodule

bind ind_cfg_port ind_cfg_port_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .host_ready_o (host_ready_o),
  .host_rdata_o (host_rdata_o),
  .dn_req_o     (dn_req_o),
  .dn_kind_o    (dn_kind_o),
  .dn_we_o      (dn_we_o),
  .dn_addr_o    (dn_addr_o),
  .dn_be_o      (dn_be_o),
  .dn_wdata_o   (dn_wdata_o),
  .dn_ack_i     (dn_ack_i)
);

// File: tb/ind_cfg_port_bench.sv
`timescale 1ns/1ps
module ind_cfg_port_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        host_req_i = 1'b0, host_we_i = 1'b0;
  logic [11:0] host_addr_i = '0;
  logic [1:0]  host_size_i = 2'b10;
  logic [31:0] host_wdata_i = '0;
  logic [31:0] host_rdata_o;
  logic        host_ready_o;
  logic        dn_req_o, dn_kind_o, dn_we_o;
  logic [31:0] dn_addr_o, dn_wdata_o;
  logic [3:0]  dn_be_o;
  logic        dn_ack_i = 1'b0;
  logic [31:0] dn_rdata_i = '0;

  int total = 0;
  int bad = 0;

  always #2.5 clk_i = ~clk_i;

  ind_cfg_port u_ind_cfg_port (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] ofs);
    if (sz == 2'b00) return 4'(1 << ofs);
    if (sz == 2'b01) return ofs[1] ? 4'hC : 4'h3;
    return 4'hF;
  endfunction

  function automatic logic [31:0] exp_mask(input logic [3:0] be);
    logic [31:0] m = '0;
    for (int b = 0; b < 4; b++) if (be[b]) m = m | (32'hFF << (8*b));
    return m;
  endfunction

  task automatic reg_write(input logic [31:0] v);
    @(negedge clk_i);
    host_req_i = 1; host_we_i = 1; host_addr_i = 12'h064; host_size_i = 2'b10; host_wdata_i = v;
    #1 chk("R2 write ready", {31'b0, host_ready_o}, 1);
    chk("R2 no downstream", {31'b0, dn_req_o}, 0);
    @(negedge clk_i);
    host_req_i = 0; host_we_i = 0;
  endtask

  task automatic reg_read(input string tag, input logic [31:0] exp);
    @(negedge clk_i);
    host_req_i = 1; host_we_i = 0; host_addr_i = 12'h064; host_size_i = 2'b10;
    #1 chk(tag, host_rdata_o, exp);
    chk({tag, " ready"}, {31'b0, host_ready_o}, 1);
    @(negedge clk_i);
    host_req_i = 0;
  endtask

  task automatic win(input string tag, input bit io, input bit we, input logic [1:0] sz,
                     input logic [1:0] ofs, input logic [31:0] wd, input int lat,
                     input logic [31:0] rsp, input logic [31:0] exp_addr);
    logic [3:0]  be = exp_be(sz, ofs);
    logic [31:0] m  = exp_mask(be);
    @(negedge clk_i);
    host_req_i = 1; host_we_i = we; host_size_i = sz; host_wdata_i = wd;
    host_addr_i = (io ? 12'h06C : 12'h068) | 12'(ofs);
    #1 chk({tag, " R7 ready low at launch"}, {31'b0, host_ready_o}, 0);
    @(negedge clk_i); #1;
    chk({tag, " R7 req"}, {31'b0, dn_req_o}, 1);
    chk({tag, io ? " R4 kind" : " R3 kind"}, {31'b0, dn_kind_o}, {31'b0, io});
    chk({tag, io ? " R4 addr" : " R3 addr"}, dn_addr_o, exp_addr);
    chk({tag, " R5 be"}, {28'b0, dn_be_o}, {28'b0, be});
    chk({tag, " R6 we"}, {31'b0, dn_we_o}, {31'b0, we});
    chk({tag, " R6 wdata"}, dn_wdata_o, wd & m);
    for (int k = 0; k < lat; k++) begin
      @(negedge clk_i); #1;
      chk({tag, " R7 stall"}, {30'b0, dn_req_o, host_ready_o}, 32'b10);
    end
    dn_ack_i = 1; dn_rdata_i = rsp;
    @(negedge clk_i);
    dn_ack_i = 0; dn_rdata_i = 32'h0BAD_0BAD;
    #1 chk({tag, " R7 ready after ack"}, {30'b0, dn_req_o, host_ready_o}, 32'b01);
    chk({tag, " R7 rdata"}, host_rdata_o, we ? 32'h0 : (rsp & m));
    host_req_i = 0; host_we_i = 0;
    @(negedge clk_i); #1;
    chk({tag, " R7 single ready"}, {30'b0, dn_req_o, host_ready_o}, 32'b00);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] a;
    repeat (3) @(negedge clk_i);
    #1 chk("R1 no request in reset", {31'b0, dn_req_o}, 0);
    rst_ni = 1;
    @(negedge clk_i); #1;
    chk("R1 no request after reset", {31'b0, dn_req_o}, 0);
    chk("R1 ready idle", {31'b0, host_ready_o}, 0);
    reg_read("R1 address reg reset", 32'h0);

    reg_write(32'hA5C3_1E74);
    reg_read("R2 readback", 32'hA5C3_1E74);

    // sweep kinds, directions, sizes and offsets
    for (int i = 0; i < 48; i++) begin
      bit io = i[0];
      bit we = i[1];
      logic [1:0] sz = 2'(i[3:2] % 3);
      logic [1:0] ofs = 2'(i / 12);
      logic [7:0] bus = 8'(i * 37 + 5), dfn = 8'(i * 11 + 3), rg = 8'(i * 29 + 1);
      a = {8'h9E ^ 8'(i), bus, dfn, rg};
      reg_write(a);
      win($sformatf("sweep%0d", i), io, we, sz, ofs, 32'h1357_9BDF ^ (32'(i) * 32'h0101_0101),
          i % 4, 32'hF00D_C0DE ^ (32'(i) << 7),
          io ? {16'h0, a[15:0]} : {8'h00, bus, dfn, rg & 8'hFC});
    end

    // R8: address write attempted while a cycle is outstanding
    reg_write(32'h0012_3456);
    @(negedge clk_i);
    host_req_i = 1; host_we_i = 0; host_addr_i = 12'h068; host_size_i = 2'b10;
    @(negedge clk_i);
    host_addr_i = 12'h064; host_we_i = 1; host_wdata_i = 32'hDEAD_BEEF;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i); #1;
      chk("R8 stall ready", {31'b0, host_ready_o}, 0);
      chk("R8 addr stable", dn_addr_o, 32'h0012_3454);
    end
    dn_ack_i = 1; dn_rdata_i = 32'h1;
    @(negedge clk_i);
    dn_ack_i = 0; host_req_i = 0; host_we_i = 0;
    reg_read("R8 register kept", 32'h0012_3456);

    // R9: priming read with register field zero, then the write
    reg_write(32'h0007_4800);
    win("R9 prime", 1'b0, 1'b0, 2'b10, 2'b00, 32'h0, 1, 32'h1234_5678, 32'h0007_4800);
    reg_read("R9 register after prime", 32'h0007_4800);
    win("R9 write", 1'b0, 1'b1, 2'b01, 2'b10, 32'hABCD_0000, 0, 32'h0, 32'h0007_4800);

    // R10: unmapped offset
    @(negedge clk_i);
    host_req_i = 1; host_we_i = 1; host_addr_i = 12'h070; host_size_i = 2'b10; host_wdata_i = 32'hFFFF_FFFF;
    #1 chk("R10 ready", {31'b0, host_ready_o}, 1);
    chk("R10 rdata", host_rdata_o, 32'h0);
    @(negedge clk_i);
    host_req_i = 0; host_we_i = 0;
    #1 chk("R10 no downstream", {31'b0, dn_req_o}, 0);
    reg_read("R10 register unchanged", 32'h0007_4800);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule